// File: doc/BRIEF.md
# Display List Coprocessor Sequencer

This block is a small beam-synchronised coprocessor. It walks a display list held in memory and uses the position of the video beam to decide when register writes land. Every instruction is two 16-bit words. It fetches them through a memory read port, using only the odd memory slots that the bus schedule offers it. It then does one of three things:

- writes an immediate value to a register address;
- stalls until the beam reaches a programmed position;
- tests the beam position once and skips the next instruction if that position has been reached.

A compare can also be made to wait for the blitter-finished input.

Software controls the program counter through two 20-bit location registers, each with its own jump strobe. A vertical-blank pulse reloads the program counter from the first location register, so a list restarts every frame. A DMA-enable input freezes fetching. The register-write bus carries the write of a move. On every other instruction-word fetch it carries a fixed fetch identity, and at all other times it carries an idle code.

Top module: `dlist_seq`

## Requirements
- R1: A first word with bit 0 = 0 is a move, and its bits 8..1 give the destination (the destination's bit 0 is forced to 0). In the cycle after the second word's granted fetch, `reg_wr` is 1, `reg_addr` is that destination and `reg_data` is the second word.
- R2: A move whose first word has any of bits 15..9 set writes nothing. Execution continues with the next instruction.
- R3: `bus_req` is only ever high while `slot_odd` is high. With a grant on every request, consecutive moves write 4 clock cycles apart.
- R4: In the cycle after each granted fetch other than a move's second word, `reg_addr` equals FETCH_ID (9'h1FE) with `reg_wr` = 0. When there is no write and no fetch, `reg_addr` is IDLE_ID (9'h1FF).
- R5: A first word with bit 0 = 1 is a compare. Its bits 15..8 are the vertical target and bits 7..1 are horizontal target bits 8..2. The compare is met when the masked value {beam_v, beam_h[8:2]} is greater than or equal to the masked target.
- R6: A compare whose second word has bit 0 = 0 is a wait. It makes no bus request until the compare is met, then fetches the next instruction.
- R7: In the second word of a compare, bits 14..8 enable vertical bits 6..0 and bits 7..1 enable horizontal bits 8..2. Vertical bit 7 is always compared.
- R8: When bit 15 of a compare's second word is 0, `blit_done` must also be 1 for the compare to be met. When that bit is 1, `blit_done` is ignored.
- R9: A compare whose second word has bit 0 = 1 is a skip. If the compare is met at the second word's fetch, the following instruction is passed over. Otherwise that instruction runs.
- R10: `loc1_we` and `loc2_we` load `loc_data` into location register 1 or 2. `jmp1_stb` or `jmp2_stb` copies that register into the program counter and starts a new instruction. If both strobes are high, strobe 1 wins.
- R11: `vblank` reloads the program counter from location register 1, ending a pending wait.
- R12: While `dma_en` is 0 there is no bus request and the program counter and sequence state hold, though a jump or `vblank` still loads the counter.
- R13: The program counter steps 2 per fetched word and wraps within 20 bits.
- R14: After reset, `reg_wr` is 0, `reg_addr` is IDLE_ID and the program counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_en | input | 1 | Enables fetching |
| slot_odd | input | 1 | High in memory slots the block may request |
| bus_req | output | 1 | Memory read request for the word at `mem_addr` |
| bus_gnt | input | 1 | Priority grant; with `bus_req` the word is read this cycle |
| mem_addr | output | 20 | Byte address of the word being fetched |
| mem_rdata | input | 16 | Word read, valid in the granted cycle |
| reg_wr | output | 1 | Register write strobe |
| reg_addr | output | 9 | Write address, fetch identity or idle code |
| reg_data | output | 16 | Write data |
| beam_v | input | 8 | Vertical beam position |
| beam_h | input | 9 | Horizontal beam position |
| blit_done | input | 1 | Blitter finished flag |
| loc_data | input | 20 | Value for a location register |
| loc1_we | input | 1 | Load location register 1 |
| loc2_we | input | 1 | Load location register 2 |
| jmp1_stb | input | 1 | Jump to location register 1 |
| jmp2_stb | input | 1 | Jump to location register 2 |
| vblank | input | 1 | Start-of-vertical-blank pulse |

## Verification
The embedded assertions check, on every cycle, the rules that hold step by step:

- each register write traces back to a granted move second-word fetch;
- the fetch identity never appears together with a write;
- the counter steps by two after a first-word fetch;
- a load always lands in the counter;
- a disabled machine stays frozen;
- a wait that is not met stays in its holding state;
- a location register takes the written value.

Only the directed scenarios can show the effects that depend on a whole instruction stream:

- a skip passing over exactly one instruction;
- the mask bits and the unmaskable vertical bit;
- the blitter condition;
- the four-cycle instruction spacing;
- fetch-identity counts;
- wrap across the top of the address space;
- a list restarting from vertical blank.

// File: rtl/dls_pkg.sv
// Package: instruction word layouts and sequence states shared by the
// display list sequencer. Assumes 16-bit instruction words.
package dls_pkg;

    localparam int WORD_W  = 16;   // instruction word width
    localparam int RA_W    = 9;    // register address width
    localparam int VPOS_W  = 8;    // vertical beam bits compared
    localparam int HPOS_W  = 7;    // horizontal beam bits compared (8..2)
    localparam int HBEAM_W = 9;    // horizontal beam input width
    localparam int CMP_W   = VPOS_W + HPOS_W;

    typedef enum logic [1:0] {
        ST_WORD1 = 2'd0,
        ST_WORD2 = 2'd1,
        ST_HOLD  = 2'd2
    } seq_state_t;

    // First word of a move
    typedef struct packed {
        logic [6:0] must_zero;
        logic [7:0] dest;
        logic       is_cmp;
    } move_w1_t;

    // First word of a compare
    typedef struct packed {
        logic [VPOS_W-1:0] vpos;
        logic [HPOS_W-1:0] hpos;
        logic              is_cmp;
    } cmp_w1_t;

    // Second word of a compare
    typedef struct packed {
        logic              blit_ign;
        logic [6:0]        vmask;
        logic [HPOS_W-1:0] hmask;
        logic              skip;
    } cmp_w2_t;

endpackage

// File: rtl/dls_locregs.sv
// Location registers: holds two jump locations and produces the program
// counter load request. Assumes vblank and jump strobes are single-cycle
// pulses; strobe 1 and vblank take precedence over strobe 2.
module dls_locregs #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] loc_data,
    input  logic          loc1_we,
    input  logic          loc2_we,
    input  logic          jmp1_stb,
    input  logic          jmp2_stb,
    input  logic          vblank,
    output logic          load_en,
    output logic [AW-1:0] load_addr
);
    localparam int NLOC = 2;

    logic [NLOC-1:0] we_v;
    logic [AW-1:0]   loc_q [NLOC];
    logic            past_ok;

    assign we_v = {loc2_we, loc1_we};

    generate
        for (genvar i = 0; i < NLOC; i++) begin : g_loc
            // Capture the written location value
            always_ff @(posedge clk) begin
                if (!rst_n) loc_q[i] <= '0;
                else if (we_v[i]) loc_q[i] <= loc_data;
            end
        end
    endgenerate

    // Choose the load source: register 1 for vblank or strobe 1
    always_comb begin
        load_en   = vblank | jmp1_stb | jmp2_stb;
        load_addr = (jmp2_stb && !jmp1_stb && !vblank) ? loc_q[1] : loc_q[0];
    end

    // Marks that one clock has passed since reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else past_ok <= 1'b1;
    end

    a_r10_loc_store: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(loc1_we)) |-> (loc_q[0] == $past(loc_data)));

endmodule

// File: rtl/dls_beam_cmp.sv
// Beam comparator: decides whether a compare instruction is satisfied.
// Assumes the first and second words are both presented in the same cycle.
module dls_beam_cmp
    import dls_pkg::*;
(
    input  logic [WORD_W-1:0]  w1,
    input  logic [WORD_W-1:0]  w2,
    input  logic [VPOS_W-1:0]  beam_v,
    input  logic [HBEAM_W-1:0] beam_h,
    input  logic               blit_done,
    output logic               hit
);
    cmp_w1_t          f1;
    cmp_w2_t          f2;
    logic [CMP_W-1:0] beam, tgt, mask;

    // Masked magnitude compare plus blitter condition
    always_comb begin
        f1   = cmp_w1_t'(w1);
        f2   = cmp_w2_t'(w2);
        beam = {beam_v, beam_h[HBEAM_W-1:2]};
        tgt  = {f1.vpos, f1.hpos};
        mask = {1'b1, f2.vmask, f2.hmask};
        hit  = ((beam & mask) >= (tgt & mask)) && (f2.blit_ign || blit_done);
    end

endmodule

// File: rtl/dls_core.sv
// Sequencer core: program counter, instruction registers and the two-word
// fetch state machine. Assumes a granted word arrives in the request cycle.
module dls_core
    import dls_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  logic              slot_odd,
    input  logic              bus_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              load_en,
    input  logic [AW-1:0]     load_addr,
    input  logic              cmp_hit,
    output logic              bus_req,
    output logic [AW-1:0]     mem_addr,
    output logic              fetch_take,
    output logic              move_w2,
    output logic [WORD_W-1:0] w1_q,
    output logic [WORD_W-1:0] w2_sel
);
    localparam logic [AW-1:0] STEP  = AW'(2);
    localparam logic [AW-1:0] STEP3 = AW'(6);

    seq_state_t        state;
    logic [AW-1:0]     pc;
    logic [WORD_W-1:0] ir1, ir2;
    logic              past_ok;

    // Request and decode signals for the current cycle
    always_comb begin
        bus_req    = dma_en && slot_odd && !load_en && (state != ST_HOLD);
        fetch_take = bus_req && bus_gnt;
        move_w2    = fetch_take && (state == ST_WORD2) && !ir1[0];
        mem_addr   = pc;
        w1_q       = ir1;
        w2_sel     = (state == ST_WORD2) ? mem_rdata : ir2;
    end

    // Sequence the two-word fetch, waits, skips and loads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WORD1;
            pc    <= '0;
            ir1   <= '0;
            ir2   <= '0;
        end else if (load_en) begin
            pc    <= load_addr;
            state <= ST_WORD1;
        end else if (dma_en) begin
            case (state)
                ST_WORD1: if (fetch_take) begin
                    ir1   <= mem_rdata;
                    pc    <= pc + STEP;
                    state <= ST_WORD2;
                end
                ST_WORD2: if (fetch_take) begin
                    ir2   <= mem_rdata;
                    state <= ST_WORD1;
                    if (!ir1[0]) begin
                        pc <= pc + STEP;
                    end else if (!mem_rdata[0]) begin
                        pc    <= pc + STEP;
                        state <= ST_HOLD;
                    end else if (cmp_hit) begin
                        pc <= pc + STEP3;
                    end else begin
                        pc <= pc + STEP;
                    end
                end
                ST_HOLD: if (cmp_hit) state <= ST_WORD1;
                default: state <= ST_WORD1;
            endcase
        end
    end

    // Marks that one clock has passed since reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else past_ok <= 1'b1;
    end

    a_r13_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(dma_en && fetch_take && state == ST_WORD1 && !load_en))
        |-> (pc == $past(pc) + STEP));

    a_r11_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(load_en)) |-> (pc == $past(load_addr) && state == ST_WORD1));

    a_r12_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!dma_en && !load_en)) |-> ($stable(pc) && $stable(state)));

    a_r6_hold_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(state == ST_HOLD && dma_en && !load_en && !cmp_hit))
        |-> (state == ST_HOLD));

endmodule

// File: rtl/dls_regbus.sv
// Register bus stage: registers the write of a move, the fetch identity
// or the idle code. Assumes fetch_take marks a granted instruction fetch.
module dls_regbus
    import dls_pkg::*;
#(
    parameter logic [RA_W-1:0] FETCH_ID = 9'h1FE,
    parameter logic [RA_W-1:0] IDLE_ID  = 9'h1FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_take,
    input  logic              move_w2,
    input  logic [WORD_W-1:0] w1_q,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              reg_wr,
    output logic [RA_W-1:0]   reg_addr,
    output logic [WORD_W-1:0] reg_data
);
    move_w1_t mw;
    logic     legal;
    logic     past_ok;

    // Decode the held first word of a move
    always_comb begin
        mw    = move_w1_t'(w1_q);
        legal = (mw.must_zero == '0);
    end

    // Drive the write, the fetch identity or the idle code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_wr   <= 1'b0;
            reg_addr <= IDLE_ID;
            reg_data <= '0;
        end else begin
            reg_wr   <= 1'b0;
            reg_addr <= IDLE_ID;
            if (fetch_take) begin
                if (move_w2) begin
                    if (legal) begin
                        reg_wr   <= 1'b1;
                        reg_addr <= {mw.dest, 1'b0};
                        reg_data <= mem_rdata;
                    end
                end else begin
                    reg_addr <= FETCH_ID;
                end
            end
        end
    end

    // Marks that one clock has passed since reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else past_ok <= 1'b1;
    end

    a_r1_write_source: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && reg_wr) |-> $past(fetch_take && move_w2));

    a_r4_id_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == FETCH_ID) |-> !reg_wr);

endmodule

// File: rtl/dlist_seq.sv
// Display list sequencer top: joins location registers, core, beam
// comparator and register bus stage. Assumes the bus schedule supplies
// slot_odd and the arbiter answers requests with bus_gnt in the same cycle.
module dlist_seq
    import dls_pkg::*;
#(
    parameter int              AW       = 20,
    parameter logic [RA_W-1:0] FETCH_ID = 9'h1FE,
    parameter logic [RA_W-1:0] IDLE_ID  = 9'h1FF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dma_en,
    input  logic               slot_odd,
    output logic               bus_req,
    input  logic               bus_gnt,
    output logic [AW-1:0]      mem_addr,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               reg_wr,
    output logic [RA_W-1:0]    reg_addr,
    output logic [WORD_W-1:0]  reg_data,
    input  logic [VPOS_W-1:0]  beam_v,
    input  logic [HBEAM_W-1:0] beam_h,
    input  logic               blit_done,
    input  logic [AW-1:0]      loc_data,
    input  logic               loc1_we,
    input  logic               loc2_we,
    input  logic               jmp1_stb,
    input  logic               jmp2_stb,
    input  logic               vblank
);
    logic              load_en;
    logic [AW-1:0]     load_addr;
    logic              cmp_hit;
    logic              fetch_take;
    logic              move_w2;
    logic [WORD_W-1:0] w1_q, w2_sel;

    dls_locregs #(.AW(AW)) u_loc (
        .clk(clk), .rst_n(rst_n), .loc_data(loc_data),
        .loc1_we(loc1_we), .loc2_we(loc2_we),
        .jmp1_stb(jmp1_stb), .jmp2_stb(jmp2_stb), .vblank(vblank),
        .load_en(load_en), .load_addr(load_addr)
    );

    dls_core #(.AW(AW)) u_core (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .slot_odd(slot_odd),
        .bus_gnt(bus_gnt), .mem_rdata(mem_rdata),
        .load_en(load_en), .load_addr(load_addr), .cmp_hit(cmp_hit),
        .bus_req(bus_req), .mem_addr(mem_addr), .fetch_take(fetch_take),
        .move_w2(move_w2), .w1_q(w1_q), .w2_sel(w2_sel)
    );

    dls_beam_cmp u_cmp (
        .w1(w1_q), .w2(w2_sel), .beam_v(beam_v), .beam_h(beam_h),
        .blit_done(blit_done), .hit(cmp_hit)
    );

    dls_regbus #(.FETCH_ID(FETCH_ID), .IDLE_ID(IDLE_ID)) u_reg (
        .clk(clk), .rst_n(rst_n), .fetch_take(fetch_take), .move_w2(move_w2),
        .w1_q(w1_q), .mem_rdata(mem_rdata),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_data(reg_data)
    );

endmodule

// File: tb/dlist_seq_bench.sv
`timescale 1ns/100ps
module dlist_seq_bench;
    localparam logic [8:0]  FID   = 9'h1FE;
    localparam logic [8:0]  IDL   = 9'h1FF;
    localparam logic [15:0] HALT1 = 16'hFFFF;
    localparam logic [15:0] HALT2 = 16'hFFFE;

    logic        clk = 0, rst_n = 0, dma_en = 0, slot_odd = 0, bus_gnt = 1;
    logic [19:0] mem_addr, loc_data = '0;
    logic [15:0] mem_rdata, reg_data;
    logic        bus_req, reg_wr;
    logic [8:0]  reg_addr;
    logic [7:0]  beam_v = '0;
    logic [8:0]  beam_h = '0;
    logic        blit_done = 0, loc1_we = 0, loc2_we = 0;
    logic        jmp1_stb = 0, jmp2_stb = 0, vblank = 0;
    logic [15:0] mem [0:127];

    int total = 0, bad = 0, cyc = 0;
    int wcnt = 0, id_cnt = 0, req_cnt = 0, bad_req = 0;
    logic [8:0]  log_a [8];
    logic [15:0] log_d [8];
    int          log_c [8];
    bit          done = 0;

    always #2.5 clk = ~clk;
    assign mem_rdata = mem[mem_addr[7:1]];

    dlist_seq u_dlist_seq (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .slot_odd(slot_odd),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_data(reg_data), .beam_v(beam_v), .beam_h(beam_h),
        .blit_done(blit_done), .loc_data(loc_data), .loc1_we(loc1_we),
        .loc2_we(loc2_we), .jmp1_stb(jmp1_stb), .jmp2_stb(jmp2_stb),
        .vblank(vblank)
    );

    initial forever begin
        @(posedge clk);
        cyc++;
    end
    initial forever begin
        @(negedge clk);
        slot_odd = ~slot_odd;
    end

    // Monitor half a nanosecond before each rising edge
    initial forever begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            if (reg_wr) begin
                if (wcnt < 8) begin
                    log_a[wcnt] = reg_addr;
                    log_d[wcnt] = reg_data;
                    log_c[wcnt] = cyc;
                end
                wcnt++;
            end
            if (reg_addr == FID && !reg_wr) id_cnt++;
            if (bus_req) req_cnt++;
            if (bus_req && !slot_odd) bad_req++;
        end
    end

    function automatic logic [15:0] mv1(input logic [8:0] a);
        return {7'd0, a[8:1], 1'b0};
    endfunction
    function automatic logic [15:0] cw1(input logic [7:0] v, input logic [8:0] h);
        return {v, h[8:2], 1'b1};
    endfunction
    function automatic logic [15:0] cw2(input logic bfd, input logic [6:0] vm,
                                        input logic [6:0] hm, input logic skp);
        return {bfd, vm, hm, skp};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        wcnt = 0; id_cnt = 0; req_cnt = 0; bad_req = 0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic jump(input int which, input logic [19:0] a);
        @(negedge clk);
        loc_data = a;
        if (which == 1) loc1_we = 1; else loc2_we = 1;
        @(negedge clk);
        loc1_we = 0; loc2_we = 0;
        if (which == 1) jmp1_stb = 1; else jmp2_stb = 1;
        @(negedge clk);
        jmp1_stb = 0; jmp2_stb = 0;
        clear_log();
    endtask

    task automatic t_reset();
        chk("R14 reg_wr", reg_wr, 0);
        chk("R14 reg_addr idle", reg_addr, IDL);
        chk("R14 pc", mem_addr, 0);
        chk("R12 no req while disabled", bus_req, 0);
    endtask

    task automatic t_moves();
        mem[16] = mv1(9'h080); mem[17] = 16'h1234;
        mem[18] = mv1(9'h0C2); mem[19] = 16'hBEEF;
        mem[20] = HALT1;       mem[21] = HALT2;
        jump(1, 20'h00020);
        run(40);
        chk("R1 write count", wcnt, 2);
        chk("R1 addr0", log_a[0], 9'h080);
        chk("R1 data0", log_d[0], 16'h1234);
        chk("R1 addr1", log_a[1], 9'h0C2);
        chk("R1 data1", log_d[1], 16'hBEEF);
        chk("R3 spacing", log_c[1] - log_c[0], 4);
        chk("R3 even-slot requests", bad_req, 0);
        chk("R4 fetch identity count", id_cnt, 4);
        chk("R4 idle when halted", reg_addr, IDL);
    endtask

    task automatic t_wait();
        mem[24] = cw1(8'h40, 9'h000); mem[25] = cw2(1, 7'h7F, 7'h7F, 0);
        mem[26] = mv1(9'h044);        mem[27] = 16'h5555;
        mem[28] = HALT1;              mem[29] = HALT2;
        beam_v = 8'h00;
        jump(1, 20'h00030);
        run(30);
        chk("R6 wait holds writes", wcnt, 0);
        chk("R6 wait no requests", req_cnt, 2);
        beam_v = 8'h40;
        run(20);
        chk("R5 wait met writes", wcnt, 1);
        chk("R5 wait addr", log_a[0], 9'h044);
        beam_v = 8'h00;
    endtask

    task automatic t_mask();
        mem[32] = cw1(8'h50, 9'h000); mem[33] = cw2(1, 7'h00, 7'h00, 0);
        mem[34] = mv1(9'h046);        mem[35] = 16'h6666;
        mem[36] = HALT1;              mem[37] = HALT2;
        beam_v = 8'h10;
        jump(1, 20'h00040);
        run(30);
        chk("R7 masked vertical met", wcnt, 1);
        mem[38] = cw1(8'h80, 9'h000); mem[39] = cw2(1, 7'h00, 7'h00, 0);
        mem[40] = mv1(9'h048);        mem[41] = 16'h6767;
        mem[42] = HALT1;              mem[43] = HALT2;
        jump(1, 20'h0004C);
        run(30);
        chk("R7 vertical bit 7 unmaskable", wcnt, 0);
        beam_v = 8'h00;
    endtask

    task automatic t_blit();
        mem[44] = cw1(8'h00, 9'h000); mem[45] = cw2(0, 7'h7F, 7'h7F, 0);
        mem[46] = mv1(9'h04A);        mem[47] = 16'h7070;
        mem[48] = HALT1;              mem[49] = HALT2;
        blit_done = 0;
        jump(1, 20'h00058);
        run(30);
        chk("R8 blitter holds", wcnt, 0);
        blit_done = 1;
        run(20);
        chk("R8 blitter releases", wcnt, 1);
        blit_done = 0;
    endtask

    task automatic t_skip();
        mem[50] = cw1(8'h20, 9'h000); mem[51] = cw2(1, 7'h7F, 7'h7F, 1);
        mem[52] = mv1(9'h050);        mem[53] = 16'hAAAA;
        mem[54] = mv1(9'h052);        mem[55] = 16'hBBBB;
        mem[56] = HALT1;              mem[57] = HALT2;
        beam_v = 8'h30;
        jump(1, 20'h00064);
        run(40);
        chk("R9 skip taken count", wcnt, 1);
        chk("R9 skip taken addr", log_a[0], 9'h052);
        beam_v = 8'h10;
        jump(1, 20'h00064);
        run(40);
        chk("R9 skip not taken count", wcnt, 2);
        chk("R9 skip not taken addr", log_a[0], 9'h050);
        beam_v = 8'h00;
    endtask

    task automatic t_vblank_jump2();
        mem[60] = mv1(9'h060); mem[61] = 16'h7777;
        mem[62] = HALT1;       mem[63] = HALT2;
        jump(1, 20'h00078);
        run(30);
        chk("R10 jump1 write", wcnt, 1);
        clear_log();
        @(negedge clk) vblank = 1;
        @(negedge clk) vblank = 0;
        run(30);
        chk("R11 vblank restart", wcnt, 1);
        chk("R11 vblank addr", log_a[0], 9'h060);
        mem[66] = mv1(9'h062); mem[67] = 16'h8888;
        mem[68] = HALT1;       mem[69] = HALT2;
        jump(2, 20'h00084);
        run(30);
        chk("R10 jump2 write", wcnt, 1);
        chk("R10 jump2 data", log_d[0], 16'h8888);
    endtask

    task automatic t_illegal();
        mem[72] = 16'h0200 | mv1(9'h064); mem[73] = 16'h1111;
        mem[74] = mv1(9'h066);            mem[75] = 16'h2222;
        mem[76] = HALT1;                  mem[77] = HALT2;
        jump(1, 20'h00090);
        run(40);
        chk("R2 illegal move suppressed", wcnt, 1);
        chk("R2 next move runs", log_a[0], 9'h066);
    endtask

    task automatic t_wrap();
        mem[127] = mv1(9'h068); mem[0] = 16'h9999;
        mem[1]   = HALT1;       mem[2] = HALT2;
        jump(1, 20'hFFFFE);
        run(30);
        chk("R13 wrap write", wcnt, 1);
        chk("R13 wrap data", log_d[0], 16'h9999);
        chk("R13 pc after wrap", mem_addr, 20'h00006);
    endtask

    task automatic t_dma();
        mem[80] = mv1(9'h06A); mem[81] = 16'h3333;
        mem[82] = HALT1;       mem[83] = HALT2;
        dma_en = 0;
        jump(1, 20'h000A0);
        run(20);
        chk("R12 no requests", req_cnt, 0);
        chk("R12 no writes", wcnt, 0);
        chk("R12 pc loaded and held", mem_addr, 20'h000A0);
        dma_en = 1;
        run(20);
        chk("R12 resumes", wcnt, 1);
        chk("R3 even-slot requests overall", bad_req, 0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = (i % 2 == 0) ? HALT1 : HALT2;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        dma_en = 1;
        run(10);
        t_moves();
        t_wait();
        t_mask();
        t_blit();
        t_skip();
        t_vblank_jump2();
        t_illegal();
        t_wrap();
        t_dma();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule